// File: doc/BRIEF.md
# Byte-Packing Word FIFO Interface

This block sits between a host that moves 32-bit words and a serial engine that moves one byte at a time. The transmit path has a word FIFO that the host fills. An unpacker pulls words from it and presents their bytes to the engine one at a time, least significant lane first. The receive path does the reverse. A packer gathers the engine's bytes into words and pushes them into a second word FIFO, where the host reads them.

A transfer starts with a one-cycle start pulse that carries a byte length. Both directions count bytes against that length. The final word of a transfer may therefore be partial: its unused lanes are dropped on transmit and filled with zeros on receive. The block has a small interrupt status vector. One bit follows the transmit watermark as a live level. The other bits are sticky and are cleared by writing ones. They flag the receive watermark, the storing of the final receive word, a write to a full transmit FIFO and a read from an empty receive FIFO. The host sees the receive FIFO fill level directly.

Top module: `bytepack_fifo_if`

## Requirements
- R1: The engine receives transmit bytes in lane order. Byte p of a word comes from bits 8p+7:8p. `eng_tx_valid` and `eng_tx_data` stay unchanged until the byte is taken with `eng_tx_ready`.
- R2: A transmit transfer presents exactly `xfer_len` bytes. The unused upper lanes of a partial last word are never presented, and `eng_tx_valid` stays low once the count is used up.
- R3: The receive packer places the k-th byte of a word in bits 8k+7:8k. It pushes one word into the receive FIFO after every fourth byte.
- R4: When `xfer_len` is not a multiple of four, the last receive word holds the remaining bytes and zeros in its upper lanes. Bytes offered after the length is used up are ignored.
- R5: `rx_level` gives the number of words stored in the receive FIFO. A read strobe on a non-empty FIFO shows the oldest word on `rx_rd_data` from the next cycle.
- R6: `irq_status[1]` is set while `rx_level` is at or above the receive watermark, and a watermark of 0 disables it. The receive watermark resets to 1 and is loaded from `wm_value` by `rx_wm_set`.
- R7: `irq_status[2]` is set in the cycle that the final word of a receive transfer is stored, and not before.
- R8: `irq_status[0]` is a live flag: it is 1 while the transmit FIFO level is below the transmit watermark. That watermark resets to DEPTH-1, is loaded by `tx_wm_set`, and a value of 0 keeps the flag at 0.
- R9: Writing a one to bit i of `irq_clear`, for i from 1 to 4, clears that status bit, unless the same bit is set again in that cycle. A clear of bit 0 has no effect.
- R10: A write to a full transmit FIFO is dropped and sets `irq_status[3]`.
- R11: A read strobe on an empty receive FIFO is dropped, leaves `rx_rd_data` unchanged and sets `irq_status[4]`.
- R12: `xfer_start` reloads the byte count and clears the lane position and any partly packed word in both directions. FIFO contents are kept.
- R13: After reset, `rx_level` is 0, `eng_tx_valid` is 0 and `irq_status` settles to 5'b00001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start | input | 1 | Start a transfer; loads the byte count |
| xfer_len | input | LEN_W | Transfer length in bytes |
| tx_wm_set | input | 1 | Load the transmit watermark from wm_value |
| rx_wm_set | input | 1 | Load the receive watermark from wm_value |
| wm_value | input | CNT_W | Watermark value |
| tx_wr_en | input | 1 | Host write strobe for the transmit FIFO |
| tx_wr_data | input | 32 | Host transmit word |
| rx_rd_en | input | 1 | Host read strobe for the receive FIFO |
| rx_rd_data | output | 32 | Word read from the receive FIFO |
| rx_level | output | CNT_W | Words stored in the receive FIFO |
| eng_tx_valid | output | 1 | Transmit byte available to the engine |
| eng_tx_data | output | 8 | Transmit byte |
| eng_tx_ready | input | 1 | Engine takes the transmit byte |
| eng_rx_valid | input | 1 | Engine delivers a receive byte |
| eng_rx_data | input | 8 | Receive byte |
| irq_clear | input | 5 | Write-one-to-clear strobes for the status bits |
| irq_status | output | 5 | Interrupt status vector |

## Verification
The hardest condition to reach from the ports is a dropped write to a full transmit FIFO. Showing that the dropped word really did not enter the queue is just as hard. After reset the byte count is zero, so the unpacker stays idle. The bench can therefore fill all eight entries and then write a ninth, distinct word. It then starts a transfer longer than the queued data and confirms that exactly the eight stored words come out, byte for byte, with nothing after them. A restart in the middle of a receive transfer is reached by offering a few bytes under one length and then pulsing start with a new length. The bench then checks that the stored word holds only the later bytes.

// File: rtl/bytepack_pkg.sv
package bytepack_pkg;
  localparam int LANES     = 4;
  localparam int WORD_W    = 32;
  localparam int IRQ_N     = 5;
  localparam int IRQ_TXWM  = 0;
  localparam int IRQ_RXWM  = 1;
  localparam int IRQ_LAST  = 2;
  localparam int IRQ_TXOVF = 3;
  localparam int IRQ_RXUDF = 4;
endpackage

// File: rtl/bp_sync_fifo.sv
module bp_sync_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic             do_wr, do_rd;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;

  // storage without reset so it can map onto block RAM
  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (do_rd) rd_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_wr) wptr <= wptr + 1'b1;
      if (do_rd) rptr <= rptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/bp_tx_unpack.sv
module bp_tx_unpack
  import bytepack_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  len,
  input  logic              fifo_empty,
  output logic              fifo_rd,
  input  logic [WORD_W-1:0] fifo_data,
  output logic              byte_valid,
  output logic [7:0]        byte_data,
  input  logic              byte_ready
);
  logic [LEN_W-1:0]  remain;
  logic [1:0]        lane;
  logic [WORD_W-1:0] word_q;
  logic              have_word, pend, take;

  assign fifo_rd    = !have_word && !pend && !fifo_empty && (remain != '0) && !start;
  assign byte_valid = have_word;
  assign byte_data  = word_q[{lane, 3'b000} +: 8];
  assign take       = have_word && byte_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain    <= '0;
      lane      <= '0;
      word_q    <= '0;
      have_word <= 1'b0;
      pend      <= 1'b0;
    end else if (start) begin
      remain    <= len;
      lane      <= '0;
      have_word <= 1'b0;
      pend      <= 1'b0;
    end else begin
      pend <= fifo_rd;
      if (pend) begin
        word_q    <= fifo_data;
        have_word <= 1'b1;
        lane      <= '0;
      end else if (take) begin
        remain <= remain - 1'b1;
        lane   <= lane + 1'b1;
        if (lane == 2'd3 || remain == LEN_W'(1)) have_word <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bp_rx_pack.sv
module bp_rx_pack
  import bytepack_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  len,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  output logic              push,
  output logic [WORD_W-1:0] push_data,
  output logic              last_evt
);
  logic [LEN_W-1:0]  remain;
  logic [1:0]        lane;
  logic [WORD_W-1:0] acc;
  logic              take;

  assign take     = byte_valid && (remain != '0) && !start;
  assign push     = take && (lane == 2'd3 || remain == LEN_W'(1));
  assign last_evt = take && (remain == LEN_W'(1));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign push_data[g*8 +: 8] = (lane == 2'(g)) ? byte_data : acc[g*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      lane   <= '0;
      acc    <= '0;
    end else if (start) begin
      remain <= len;
      lane   <= '0;
      acc    <= '0;
    end else if (take) begin
      remain <= remain - 1'b1;
      if (push) begin
        acc  <= '0;
        lane <= '0;
      end else begin
        acc  <= push_data;
        lane <= lane + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bp_irq_ctrl.sv
module bp_irq_ctrl
  import bytepack_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] tx_count,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] wm_value,
  input  logic             tx_wm_set,
  input  logic             rx_wm_set,
  input  logic             ev_last,
  input  logic             ev_tx_ovf,
  input  logic             ev_rx_udf,
  input  logic [IRQ_N-1:0] clr,
  output logic [IRQ_N-1:0] status
);
  logic [CNT_W-1:0] tx_wm, rx_wm;
  logic [IRQ_N-1:0] set_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_wm <= CNT_W'(DEPTH - 1);
      rx_wm <= CNT_W'(1);
    end else begin
      if (tx_wm_set) tx_wm <= wm_value;
      if (rx_wm_set) rx_wm <= wm_value;
    end
  end

  always_comb begin
    set_v            = '0;
    set_v[IRQ_RXWM]  = (rx_wm != '0) && (rx_count >= rx_wm);
    set_v[IRQ_LAST]  = ev_last;
    set_v[IRQ_TXOVF] = ev_tx_ovf;
    set_v[IRQ_RXUDF] = ev_rx_udf;
  end

  always_ff @(posedge clk) begin
    if (rst) status[IRQ_TXWM] <= 1'b0;
    else     status[IRQ_TXWM] <= (tx_count < tx_wm);
  end

  for (genvar i = 1; i < IRQ_N; i++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (rst) status[i] <= 1'b0;
      else     status[i] <= set_v[i] | (status[i] & ~clr[i]);
    end
  end
endmodule

// File: rtl/bytepack_fifo_if.sv
module bytepack_fifo_if
  import bytepack_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LEN_W = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer_start,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic              tx_wm_set,
  input  logic              rx_wm_set,
  input  logic [CNT_W-1:0]  wm_value,
  input  logic              tx_wr_en,
  input  logic [31:0]       tx_wr_data,
  input  logic              rx_rd_en,
  output logic [31:0]       rx_rd_data,
  output logic [CNT_W-1:0]  rx_level,
  output logic              eng_tx_valid,
  output logic [7:0]        eng_tx_data,
  input  logic              eng_tx_ready,
  input  logic              eng_rx_valid,
  input  logic [7:0]        eng_rx_data,
  input  logic [IRQ_N-1:0]  irq_clear,
  output logic [IRQ_N-1:0]  irq_status
);
  logic [CNT_W-1:0]  tx_count;
  logic              tx_full, tx_empty, tx_rd;
  logic [WORD_W-1:0] tx_head;
  logic              rx_full, rx_empty, rx_push, rx_last;
  logic [WORD_W-1:0] rx_word;

  bp_sync_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_txf (
    .clk(clk), .rst(rst),
    .wr_en(tx_wr_en), .wr_data(tx_wr_data),
    .rd_en(tx_rd), .rd_data(tx_head),
    .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  bp_tx_unpack #(.LEN_W(LEN_W)) u_unpack (
    .clk(clk), .rst(rst), .start(xfer_start), .len(xfer_len),
    .fifo_empty(tx_empty), .fifo_rd(tx_rd), .fifo_data(tx_head),
    .byte_valid(eng_tx_valid), .byte_data(eng_tx_data), .byte_ready(eng_tx_ready)
  );

  bp_rx_pack #(.LEN_W(LEN_W)) u_pack (
    .clk(clk), .rst(rst), .start(xfer_start), .len(xfer_len),
    .byte_valid(eng_rx_valid), .byte_data(eng_rx_data),
    .push(rx_push), .push_data(rx_word), .last_evt(rx_last)
  );

  bp_sync_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_rxf (
    .clk(clk), .rst(rst),
    .wr_en(rx_push), .wr_data(rx_word),
    .rd_en(rx_rd_en), .rd_data(rx_rd_data),
    .count(rx_level), .full(rx_full), .empty(rx_empty)
  );

  bp_irq_ctrl #(.DEPTH(DEPTH)) u_irq (
    .clk(clk), .rst(rst),
    .tx_count(tx_count), .rx_count(rx_level),
    .wm_value(wm_value), .tx_wm_set(tx_wm_set), .rx_wm_set(rx_wm_set),
    .ev_last(rx_last && !rx_full),
    .ev_tx_ovf(tx_wr_en && tx_full),
    .ev_rx_udf(rx_rd_en && rx_empty),
    .clr(irq_clear), .status(irq_status)
  );
endmodule

// File: rtl/bytepack_fifo_if_chk.sv
module bytepack_fifo_if_chk #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_wr_en,
  input logic             tx_full,
  input logic             rx_rd_en,
  input logic [CNT_W-1:0] rx_level,
  input logic [31:0]      rx_rd_data,
  input logic             eng_tx_valid,
  input logic             eng_tx_ready,
  input logic [7:0]       eng_tx_data,
  input logic             eng_rx_valid,
  input logic [4:0]       irq_clear,
  input logic [4:0]       irq_status
);
  assert_tx_hold_R1: assert property (@(posedge clk) disable iff (rst)
    eng_tx_valid && !eng_tx_ready |=> eng_tx_valid && $stable(eng_tx_data));

  assert_rx_grow_R3: assert property (@(posedge clk) disable iff (rst)
    !eng_rx_valid |=> rx_level <= $past(rx_level));

  assert_rx_bound_R5: assert property (@(posedge clk) disable iff (rst)
    rx_level <= CNT_W'(DEPTH));

  assert_last_clear_R9: assert property (@(posedge clk) disable iff (rst)
    irq_clear[2] && !eng_rx_valid |=> !irq_status[2]);

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    tx_wr_en && tx_full |=> irq_status[3]);

  assert_empty_read_R11: assert property (@(posedge clk) disable iff (rst)
    rx_rd_en && rx_level == '0 |=> irq_status[4] && $stable(rx_rd_data));
endmodule

bind bytepack_fifo_if bytepack_fifo_if_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst),
  .tx_wr_en(tx_wr_en), .tx_full(tx_full),
  .rx_rd_en(rx_rd_en), .rx_level(rx_level), .rx_rd_data(rx_rd_data),
  .eng_tx_valid(eng_tx_valid), .eng_tx_ready(eng_tx_ready), .eng_tx_data(eng_tx_data),
  .eng_rx_valid(eng_rx_valid), .irq_clear(irq_clear), .irq_status(irq_status)
);

// File: tb/bytepack_fifo_if_tb.sv
module bytepack_fifo_if_tb;
  localparam int DEPTH = 8;
  localparam int LEN_W = 16;
  localparam int CNT_W = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic xfer_start = 0;
  logic [LEN_W-1:0] xfer_len = '0;
  logic tx_wm_set = 0, rx_wm_set = 0;
  logic [CNT_W-1:0] wm_value = '0;
  logic tx_wr_en = 0;
  logic [31:0] tx_wr_data = '0;
  logic rx_rd_en = 0;
  logic [31:0] rx_rd_data;
  logic [CNT_W-1:0] rx_level;
  logic eng_tx_valid;
  logic [7:0] eng_tx_data;
  logic eng_tx_ready = 0;
  logic eng_rx_valid = 0;
  logic [7:0] eng_rx_data = '0;
  logic [4:0] irq_clear = '0;
  logic [4:0] irq_status;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [7:0] got [0:63];
  int ngot;

  always #4 clk = ~clk;

  bytepack_fifo_if #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_dut (.*);

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    repeat (2) step();
  endtask

  task automatic start_xfer(input int n);
    xfer_start = 1'b1; xfer_len = LEN_W'(n);
    step();
    xfer_start = 1'b0;
  endtask

  task automatic tx_write(input logic [31:0] d);
    tx_wr_en = 1'b1; tx_wr_data = d;
    step();
    tx_wr_en = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] b);
    eng_rx_valid = 1'b1; eng_rx_data = b;
    step();
    eng_rx_valid = 1'b0;
  endtask

  task automatic rx_read(output logic [31:0] d);
    rx_rd_en = 1'b1;
    step();
    rx_rd_en = 1'b0;
    d = rx_rd_data;
  endtask

  task automatic clear(input logic [4:0] m);
    irq_clear = m;
    step();
    irq_clear = '0;
  endtask

  task automatic set_wm(input bit tx, input int v);
    wm_value = CNT_W'(v);
    if (tx) tx_wm_set = 1'b1; else rx_wm_set = 1'b1;
    step();
    tx_wm_set = 1'b0; rx_wm_set = 1'b0;
  endtask

  task automatic collect(input int cycles, input bit bp);
    ngot = 0;
    for (int c = 0; c < cycles; c++) begin
      eng_tx_ready = bp ? c[0] : 1'b1;
      if (eng_tx_valid && eng_tx_ready && ngot < 64) begin
        got[ngot] = eng_tx_data;
        ngot++;
      end
      step();
    end
    eng_tx_ready = 1'b0;
  endtask

  function automatic logic [7:0] txpat(input int l, input int i);
    return 8'((l * 16 + i * 7 + 3) & 255);
  endfunction

  function automatic logic [7:0] rxpat(input int l, input int i);
    return 8'((l * 5 + i * 11 + 1) & 255);
  endfunction

  initial begin
    logic [31:0] w, exp_w, last_w;
    do_reset();
    // R13 reset state
    chk("R13 status", 32'(irq_status), 32'h1);
    chk("R13 rx_level", 32'(rx_level), 0);
    chk("R13 tx_valid", 32'(eng_tx_valid), 0);

    // R8 fill to the default watermark, R10 overflow, drain proves it was dropped
    for (int k = 0; k < DEPTH - 1; k++) tx_write({8'(k*4+19), 8'(k*4+18), 8'(k*4+17), 8'(k*4+16)});
    step(); step();
    chk("R8 level at wm", 32'(irq_status[0]), 0);
    tx_write({8'(DEPTH*4+15), 8'(DEPTH*4+14), 8'(DEPTH*4+13), 8'(DEPTH*4+12)});
    tx_write(32'hDEADBEEF);
    step();
    chk("R10 overflow flag", 32'(irq_status[3]), 1);
    clear(5'b11111);
    step();
    chk("R9 clear overflow", 32'(irq_status[3]), 0);
    chk("R9 live bit not cleared", 32'(irq_status[0]), 0);
    start_xfer(DEPTH * 4 + 4);
    collect(DEPTH * 24, 1'b0);
    chk("R10 bytes drained", ngot, DEPTH * 4);
    for (int i = 0; i < DEPTH * 4 && i < ngot; i++) chk("R10 drained byte", 32'(got[i]), 32'(i + 16));
    chk("R8 below wm after drain", 32'(irq_status[0]), 1);
    clear(5'b00001);
    chk("R9 bit0 unaffected by clear", 32'(irq_status[0]), 1);
    set_wm(1'b1, 0);
    step();
    chk("R8 wm zero disables", 32'(irq_status[0]), 0);

    // R1 R2 sweep of transmit lengths, with and without back-pressure
    for (int l = 1; l <= 12; l++) begin
      do_reset();
      start_xfer(l);
      for (int wi = 0; wi < (l + 3) / 4; wi++) begin
        for (int p = 0; p < 4; p++)
          w[p*8 +: 8] = (wi*4 + p < l) ? txpat(l, wi*4 + p) : 8'(8'hE0 | p);
        tx_write(w);
      end
      collect(l * 8 + 40, l[0]);
      chk("R2 byte count", ngot, l);
      for (int i = 0; i < l && i < ngot; i++) chk("R1 byte value", 32'(got[i]), 32'(txpat(l, i)));
      chk("R2 valid low after length", 32'(eng_tx_valid), 0);
    end

    // R3 R4 R5 R7 R6 R9 R11 sweep of receive lengths
    for (int l = 1; l <= 12; l++) begin
      do_reset();
      start_xfer(l);
      for (int i = 0; i < l; i++) begin
        if (i == l - 1 && l > 1) chk("R7 not before final", 32'(irq_status[2]), 0);
        rx_push(rxpat(l, i));
      end
      rx_push(8'hA5);
      rx_push(8'h5A);
      step();
      chk("R5 rx_level", 32'(rx_level), (l + 3) / 4);
      chk("R7 last flag", 32'(irq_status[2]), 1);
      chk("R6 default rx wm", 32'(irq_status[1]), 1);
      for (int wi = 0; wi < (l + 3) / 4; wi++) begin
        for (int p = 0; p < 4; p++)
          exp_w[p*8 +: 8] = (wi*4 + p < l) ? rxpat(l, wi*4 + p) : 8'h00;
        rx_read(w);
        chk(wi == (l - 1) / 4 ? "R4 last word" : "R3 packed word", w, exp_w);
      end
      last_w = rx_rd_data;
      chk("R5 level empty", 32'(rx_level), 0);
      clear(5'b00110);
      chk("R9 clear wm and last", 32'(irq_status[2:1]), 0);
      rx_read(w);
      chk("R11 empty read data", w, last_w);
      step();
      chk("R11 underflow flag", 32'(irq_status[4]), 1);
      clear(5'b10000);
      chk("R9 clear underflow", 32'(irq_status[4]), 0);
    end

    // R6 programmed receive watermark
    do_reset();
    set_wm(1'b0, 3);
    start_xfer(12);
    for (int i = 0; i < 8; i++) rx_push(8'(i));
    step(); step();
    chk("R6 below wm", 32'(irq_status[1]), 0);
    for (int i = 8; i < 12; i++) rx_push(8'(i));
    step(); step();
    chk("R6 at wm", 32'(irq_status[1]), 1);

    // R12 restart in the middle of a receive word
    do_reset();
    start_xfer(8);
    rx_push(8'hAA);
    rx_push(8'hBB);
    start_xfer(4);
    rx_push(8'h01); rx_push(8'h02); rx_push(8'h03); rx_push(8'h04);
    step();
    chk("R12 level after restart", 32'(rx_level), 1);
    rx_read(w);
    chk("R12 word after restart", w, 32'h04030201);

    summary();
  end
endmodule